// File: doc/BRIEF.md
# T3 Transmit M-Frame Overhead and Alarm Inserter

This block builds the serial T3 M-frame on the transmit side. On every cycle where the bit-rate enable is high it emits one line bit. That bit is either an overhead bit the block makes itself (F, M, X, P or C) or an information bit. In normal operation the information bit is taken from the upstream payload source, which the block paces with a request strobe. The frame layout is set by parameters: 7 subframes, each of 8 blocks, and each block is one overhead bit followed by 84 information bits. That gives 4760 bits per frame.

Three control inputs replace the normal data with maintenance signals. The alarm indication signal fills the information bits with alternating ones and zeros and keeps the framing, the X bits and the P bits valid. The idle signal fills them with the pattern 1,1,0,0 and keeps the framing valid. Pass-through sends the payload input straight to the line with no overhead inserted. The remote alarm input controls the X bits. Two markers, registered together with each line bit, flag the first bit of the frame and the first bit of each subframe.

Top module: `t3_mframe_tx`

## Requirements
- R1: The frame is 7 subframes × 8 blocks × 85 bits, and each block starts with one overhead bit. `frame_start` is 1 exactly with the line bit at subframe 0, block 0, position 0. `subframe_start` is 1 exactly with the line bit at block 0, position 0 of any subframe.
- R2: Outside pass-through, the overhead bits of blocks 1, 3, 5 and 7 (F bits) are 1, 0, 0, 1. The block-0 overhead bits of subframes 5, 6 and 7 (M bits, indices 4 to 6) are 0, 1, 0.
- R3: The block-0 overhead bit of subframes 1 and 2 (X bits) is the inverse of `rai_en` in normal mode. It is 1 whenever AIS or idle is active.
- R4: The block-0 overhead bit of subframes 3 and 4 (P bits) equals the XOR of every information-position line bit of the previous frame. It is 0 in the first frame after reset.
- R5: The overhead bits of blocks 2, 4 and 6 (C bits) are 1 in normal mode and 0 under AIS. Under idle they are 0 in subframe 3 (index 2) and 1 in the other subframes.
- R6: Under AIS the information bits are 1,0,1,0,… and the first information bit of each frame is 1.
- R7: Under idle the information bits are 1,1,0,0,… and the pattern starts at the first information bit of each frame.
- R8: Under pass-through each line bit equals `pay_bit` as sampled on that enable, at every position.
- R9: In normal mode the information bits are the `pay_bit` values sampled on the enables where `pay_req` is high, in order.
- R10: `pay_req` is high only at information positions, and only when pass-through, AIS and idle are all off.
- R11: Priority is pass-through, then AIS, then idle, then normal. `rai_en` affects only the X bits of normal mode.
- R12: When `bit_en` is low, the position does not advance and all registered outputs hold.
- R13: Reset sets the line bit and both markers to 0, returns the position to the first bit of the frame, and clears the parity history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-rate enable, one line bit per high cycle |
| pay_bit | input | 1 | Serial payload bit, sampled when `bit_en` is high |
| ais_en | input | 1 | Send the alarm indication signal |
| rai_en | input | 1 | Send the remote alarm on the X bits |
| idle_en | input | 1 | Send the idle signal |
| thru_en | input | 1 | Pass-through, with no overhead inserted |
| line_bit | output | 1 | Registered serial line bit |
| pay_req | output | 1 | High when the current position consumes `pay_bit` |
| frame_start | output | 1 | Registered with `line_bit`: first bit of the frame |
| subframe_start | output | 1 | Registered with `line_bit`: first bit of a subframe |

## Verification
The assertions assume that the mode inputs stay steady across the enable whose result they check. They also assume that `pay_bit` is valid whenever `bit_en` is high. The stimulus changes the mode inputs only on the falling clock edge before the first bit of a frame. It presents a new payload bit with every enable, drawn from a shift-register sequence, and it inserts enable gaps only in a dedicated hold test.

// File: rtl/t3fr_pkg.sv
package t3fr_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_IDLE   = 2'd1,
    MODE_AIS    = 2'd2,
    MODE_THRU   = 2'd3
  } tx_mode_e;

  // pass-through wins, then AIS, then idle
  function automatic tx_mode_e pick_mode(input logic thru, input logic ais, input logic idle);
    if (thru)      return MODE_THRU;
    else if (ais)  return MODE_AIS;
    else if (idle) return MODE_IDLE;
    else           return MODE_NORMAL;
  endfunction

endpackage

// File: rtl/t3fr_position.sv
module t3fr_position #(
  parameter int SUBFRAMES = 7,
  parameter int BLOCKS    = 8,
  parameter int INFO_BITS = 84,
  localparam int BLK_LEN  = INFO_BITS + 1,
  localparam int SF_W     = $clog2(SUBFRAMES),
  localparam int BLK_W    = $clog2(BLOCKS),
  localparam int BIT_W    = $clog2(BLK_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [SF_W-1:0]  sf_idx,
  output logic [BLK_W-1:0] blk_idx,
  output logic [BIT_W-1:0] bit_idx,
  output logic             at_ovh,
  output logic             at_sf_first,
  output logic             at_frame_first,
  output logic             at_frame_last
);

  localparam logic [SF_W-1:0]  LAST_SF  = SF_W'(SUBFRAMES - 1);
  localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(BLOCKS - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BLK_LEN - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sf_idx  <= '0;
      blk_idx <= '0;
      bit_idx <= '0;
    end else if (adv) begin
      if (bit_idx == LAST_BIT) begin
        bit_idx <= '0;
        if (blk_idx == LAST_BLK) begin
          blk_idx <= '0;
          sf_idx  <= (sf_idx == LAST_SF) ? '0 : sf_idx + 1'b1;
        end else begin
          blk_idx <= blk_idx + 1'b1;
        end
      end else begin
        bit_idx <= bit_idx + 1'b1;
      end
    end
  end

  assign at_ovh         = (bit_idx == '0);
  assign at_sf_first    = at_ovh && (blk_idx == '0);
  assign at_frame_first = at_sf_first && (sf_idx == '0);
  assign at_frame_last  = (bit_idx == LAST_BIT) && (blk_idx == LAST_BLK) && (sf_idx == LAST_SF);

  AST_POS_RANGE: assert property (@(posedge clk) disable iff (rst)
    (bit_idx <= LAST_BIT) && (blk_idx <= LAST_BLK) && (sf_idx <= LAST_SF)); // R1

  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
    (adv && at_frame_last) |=> at_frame_first); // R1

  AST_POS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(bit_idx) && $stable(blk_idx) && $stable(sf_idx)); // R12

endmodule

// File: rtl/t3fr_parity.sv
module t3fr_parity (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic take,
  input  logic bit_in,
  input  logic frame_last,
  output logic par_prev
);

  logic acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= 1'b0;
      par_prev <= 1'b0;
    end else if (adv) begin
      if (frame_last) begin
        par_prev <= acc ^ (take & bit_in);
        acc      <= 1'b0;
      end else if (take) begin
        acc <= acc ^ bit_in;
      end
    end
  end

  AST_PAR_RESTART: assert property (@(posedge clk) disable iff (rst)
    (adv && frame_last) |=> !acc); // R4

  AST_PAR_STEADY: assert property (@(posedge clk) disable iff (rst)
    !(adv && frame_last) |=> $stable(par_prev)); // R4

endmodule

// File: rtl/t3fr_pattern.sv
module t3fr_pattern (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic info,
  input  logic frame_first,
  output logic ais_bit,
  output logic idle_bit
);

  logic [1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
    end else if (adv) begin
      if (frame_first)
        phase <= '0;
      else if (info)
        phase <= phase + 1'b1;
    end
  end

  assign ais_bit  = ~phase[0];
  assign idle_bit = ~phase[1];

  AST_PAT_RESTART: assert property (@(posedge clk) disable iff (rst)
    (adv && frame_first) |=> (ais_bit && idle_bit)); // R6

  AST_PAT_STEP: assert property (@(posedge clk) disable iff (rst)
    (adv && info && !frame_first) |=> (ais_bit != $past(ais_bit))); // R6

endmodule

// File: rtl/t3_mframe_tx.sv
module t3_mframe_tx
  import t3fr_pkg::*;
#(
  parameter int   SUBFRAMES = 7,
  parameter int   BLOCKS    = 8,
  parameter int   INFO_BITS = 84,
  parameter logic C_FILL    = 1'b1,
  localparam int  BLK_LEN   = INFO_BITS + 1,
  localparam int  SF_W      = $clog2(SUBFRAMES),
  localparam int  BLK_W     = $clog2(BLOCKS),
  localparam int  BIT_W     = $clog2(BLK_LEN)
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic pay_bit,
  input  logic ais_en,
  input  logic rai_en,
  input  logic idle_en,
  input  logic thru_en,
  output logic line_bit,
  output logic pay_req,
  output logic frame_start,
  output logic subframe_start
);

  // subframe slots of the block-0 overhead bit
  localparam logic [SF_W-1:0]  SF_P_FIRST  = SF_W'(2);
  localparam logic [SF_W-1:0]  SF_M_FIRST  = SF_W'(4);
  localparam logic [SF_W-1:0]  SF_M_ONE    = SF_W'(5);
  localparam logic [SF_W-1:0]  SF_IDLE_C   = SF_W'(2);
  localparam logic [BLK_W-1:0] BLK_F_FIRST = BLK_W'(1);
  localparam logic [BLK_W-1:0] BLK_F_LAST  = BLK_W'(BLOCKS - 1);

  logic [SF_W-1:0]  sf_idx;
  logic [BLK_W-1:0] blk_idx;
  logic [BIT_W-1:0] bit_idx;
  logic at_ovh, at_sf_first, at_frame_first, at_frame_last;
  logic par_prev, ais_bit, idle_bit;
  logic ovh_val, info_val, next_bit;
  tx_mode_e mode;

  t3fr_position #(
    .SUBFRAMES (SUBFRAMES),
    .BLOCKS    (BLOCKS),
    .INFO_BITS (INFO_BITS)
  ) pos_i (
    .clk            (clk),
    .rst            (rst),
    .adv            (bit_en),
    .sf_idx         (sf_idx),
    .blk_idx        (blk_idx),
    .bit_idx        (bit_idx),
    .at_ovh         (at_ovh),
    .at_sf_first    (at_sf_first),
    .at_frame_first (at_frame_first),
    .at_frame_last  (at_frame_last)
  );

  t3fr_parity par_i (
    .clk        (clk),
    .rst        (rst),
    .adv        (bit_en),
    .take       (!at_ovh),
    .bit_in     (next_bit),
    .frame_last (at_frame_last),
    .par_prev   (par_prev)
  );

  t3fr_pattern pat_i (
    .clk         (clk),
    .rst         (rst),
    .adv         (bit_en),
    .info        (!at_ovh),
    .frame_first (at_frame_first),
    .ais_bit     (ais_bit),
    .idle_bit    (idle_bit)
  );

  assign mode = pick_mode(thru_en, ais_en, idle_en);

  always_comb begin
    if (blk_idx == '0) begin
      if (sf_idx < SF_P_FIRST)
        ovh_val = (mode == MODE_NORMAL) ? ~rai_en : 1'b1;   // X
      else if (sf_idx < SF_M_FIRST)
        ovh_val = par_prev;                                 // P
      else
        ovh_val = (sf_idx == SF_M_ONE);                     // M
    end else if (blk_idx[0]) begin
      ovh_val = (blk_idx == BLK_F_FIRST) || (blk_idx == BLK_F_LAST); // F
    end else begin
      unique case (mode)                                    // C
        MODE_AIS:  ovh_val = 1'b0;
        MODE_IDLE: ovh_val = (sf_idx == SF_IDLE_C) ? 1'b0 : C_FILL;
        default:   ovh_val = C_FILL;
      endcase
    end
  end

  always_comb begin
    unique case (mode)
      MODE_AIS:  info_val = ais_bit;
      MODE_IDLE: info_val = idle_bit;
      default:   info_val = pay_bit;
    endcase
  end

  assign next_bit = (mode == MODE_THRU) ? pay_bit : (at_ovh ? ovh_val : info_val);
  assign pay_req  = !at_ovh && (mode == MODE_NORMAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      line_bit       <= 1'b0;
      frame_start    <= 1'b0;
      subframe_start <= 1'b0;
    end else if (bit_en) begin
      line_bit       <= next_bit;
      frame_start    <= at_frame_first;
      subframe_start <= at_sf_first;
    end
  end

  AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(line_bit) && $stable(frame_start) && $stable(subframe_start)); // R12

  AST_THRU_FORWARD: assert property (@(posedge clk) disable iff (rst)
    (bit_en && thru_en) |=> (line_bit == $past(pay_bit))); // R8

  AST_XBIT_RAI: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !thru_en && !ais_en && !idle_en && at_sf_first && (sf_idx < SF_P_FIRST))
      |=> (line_bit == !$past(rai_en))); // R3

  AST_FBIT_ONE: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !thru_en && at_ovh && (blk_idx == BLK_F_FIRST)) |=> line_bit); // R2

  AST_AIS_CBIT: assert property (@(posedge clk) disable iff (rst)
    (bit_en && ais_en && !thru_en && at_ovh && (blk_idx != '0) && !blk_idx[0]) |=> !line_bit); // R5

  AST_REQ_INFO_ONLY: assert property (@(posedge clk) disable iff (rst)
    (bit_en && pay_req) |=> !subframe_start); // R10

endmodule

// File: tb/t3_mframe_tx_tb_top.sv
`timescale 1ns/1ps
module t3_mframe_tx_tb_top;

  localparam int NSF  = 7;
  localparam int NBLK = 8;
  localparam int NBIT = 85;
  localparam int NROW = 10;
  localparam int WATCHDOG_CYC = 150000;

  // {ais, idle, rai, thru, expected X bit}
  localparam logic [4:0] ROWS [NROW] = '{
    5'b00001,   // normal, RAI off
    5'b00001,   // normal again: P from a payload frame
    5'b00100,   // normal, RAI on -> X = 0
    5'b10001,   // AIS
    5'b10101,   // AIS with RAI: X stays 1 (R11)
    5'b01001,   // idle
    5'b01101,   // idle with RAI: X stays 1
    5'b11001,   // AIS and idle: AIS wins
    5'b10011,   // pass-through over AIS
    5'b00001    // normal after pass-through
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0, pay_bit = 1'b0;
  logic ais_en = 1'b0, rai_en = 1'b0, idle_en = 1'b0, thru_en = 1'b0;
  logic line_bit, pay_req, frame_start, subframe_start;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic par_prev = 1'b0;

  always #2.5 clk = ~clk;

  t3_mframe_tx dut_i (
    .clk            (clk),
    .rst            (rst),
    .bit_en         (bit_en),
    .pay_bit        (pay_bit),
    .ais_en         (ais_en),
    .rai_en         (rai_en),
    .idle_en        (idle_en),
    .thru_en        (thru_en),
    .line_bit       (line_bit),
    .pay_req        (pay_req),
    .frame_start    (frame_start),
    .subframe_start (subframe_start)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic next_pay();
    logic b;
    b    = lfsr[0];
    lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
    return b;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bit_en = 1'b0;
    repeat (3) @(negedge clk);
    check(line_bit == 1'b0, "R13 line_bit in reset", line_bit, 0);
    check({frame_start, subframe_start} == 2'b00, "R13 markers in reset", {frame_start, subframe_start}, 0);
    rst = 1'b0;
    par_prev = 1'b0;
    #1;
    check(pay_req == 1'b0, "R13 position at frame overhead", pay_req, 0);
    @(negedge clk);
  endtask

  // one full frame, one bit per cycle, compared against the bench model
  task automatic run_frame(input logic [4:0] row);
    int err [8];
    int act [8];
    int ex  [8];
    bit seen [8];
    string lbl [8];
    int info_idx;
    logic acc;
    logic ais, idle, rai, thru, ex_x;
    bit pri;
    {ais, idle, rai, thru, ex_x} = row;
    pri = (int'(ais) + int'(idle) + int'(thru)) > 1;
    foreach (err[i]) begin err[i] = 0; act[i] = 0; ex[i] = 0; seen[i] = 0; end
    lbl[0] = "R1 markers";
    lbl[1] = "R2 F/M bits";
    lbl[2] = "R3 X bits";
    lbl[3] = "R4 P bits";
    lbl[4] = "R5 C bits";
    lbl[5] = ais ? "R6 AIS info" : (idle ? "R7 idle info" : "R9 payload info");
    lbl[6] = "R8 pass-through";
    lbl[7] = "R10 pay_req";
    info_idx = 0;
    acc = 1'b0;
    for (int sf = 0; sf < NSF; sf++) begin
      for (int blk = 0; blk < NBLK; blk++) begin
        for (int bt = 0; bt < NBIT; bt++) begin
          logic pay, e, ereq;
          int cat;
          pay = next_pay();
          ais_en = ais; idle_en = idle; rai_en = rai; thru_en = thru;
          bit_en = 1'b1; pay_bit = pay;
          #1;
          ereq = (bt != 0) && !thru && !ais && !idle;
          seen[7] = 1;
          if (pay_req !== ereq) begin
            if (err[7] == 0) begin act[7] = pay_req; ex[7] = ereq; end
            err[7]++;
          end
          if (thru) begin
            e = pay; cat = 6;
          end else if (bt == 0) begin
            if (blk == 0) begin
              if (sf < 2)      begin e = ex_x; cat = 2; end
              else if (sf < 4) begin e = par_prev; cat = 3; end
              else             begin e = (sf == 5); cat = 1; end
            end else if (blk % 2 == 1) begin
              e = (blk == 1) || (blk == NBLK - 1); cat = 1;
            end else begin
              e = ais ? 1'b0 : ((idle && sf == 2) ? 1'b0 : 1'b1); cat = 4;
            end
          end else begin
            if (ais)       e = (info_idx % 2) == 0;
            else if (idle) e = (info_idx % 4) < 2;
            else           e = pay;
            cat = 5;
          end
          if (bt != 0) begin
            acc = acc ^ e;
            info_idx++;
          end
          @(negedge clk);
          seen[cat] = 1;
          if (line_bit !== e) begin
            if (err[cat] == 0) begin act[cat] = line_bit; ex[cat] = e; end
            err[cat]++;
          end
          seen[0] = 1;
          if ({frame_start, subframe_start} !== {(sf == 0 && blk == 0 && bt == 0), (blk == 0 && bt == 0)}) begin
            if (err[0] == 0) begin
              act[0] = {frame_start, subframe_start};
              ex[0]  = {(sf == 0 && blk == 0 && bt == 0), (blk == 0 && bt == 0)};
            end
            err[0]++;
          end
        end
      end
    end
    par_prev = acc;
    for (int c = 0; c < 8; c++)
      if (seen[c]) check(err[c] == 0, pri ? {"R11/", lbl[c]} : lbl[c], act[c], ex[c]);
  endtask

  initial begin
    do_reset();
    for (int r = 0; r < NROW; r++) run_frame(ROWS[r]);

    // R12: enable gaps hold the outputs and the position
    ais_en = 1'b0; idle_en = 1'b0; thru_en = 1'b0; rai_en = 1'b0;
    bit_en = 1'b1; pay_bit = 1'b0;
    @(negedge clk);
    check(line_bit == 1'b1 && frame_start == 1'b1, "R12 first X bit before gap", {line_bit, frame_start}, 3);
    bit_en = 1'b0;
    for (int g = 0; g < 6; g++) begin
      pay_bit = g[0];
      @(negedge clk);
    end
    check(line_bit == 1'b1 && frame_start == 1'b1, "R12 outputs held during gap", {line_bit, frame_start}, 3);
    check(pay_req == 1'b1, "R12 position held at first info bit", pay_req, 1);
    bit_en = 1'b1; pay_bit = 1'b0;
    @(negedge clk);
    check(line_bit == 1'b0 && frame_start == 1'b0 && subframe_start == 1'b0,
          "R12 resume at info bit", {line_bit, frame_start, subframe_start}, 0);

    // R13: mid-frame reset, then a full frame with cleared parity
    do_reset();
    run_frame(5'b00001);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < WATCHDOG_CYC; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG_CYC, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule